// File: doc/BRIEF.md
# Static Memory Bus Cycle Timer

This block turns single host requests into chip-select, read-strobe and write-strobe waveforms for an external static memory. Every phase is measured in controller clock cycles. Each chip select has its own programmed timing set, one for reads and one for writes. Each set gives a strobe setup, a strobe pulse, a chip-select setup, a chip-select pulse and a total cycle length. The host raises a request with a direction, a chip-select number, an address and byte selects. The block runs the access and raises an acknowledge in the last cycle of it.

Power management can drop the controller clock to a very low rate, around 32 kHz. It then asserts a slow-clock indication. While that indication is high, every programmed value is ignored, and one fixed built-in timing set is used on all chip selects. Software therefore does not have to rewrite the timing registers before or after the clock change.

The block is built around a two-state machine. `ST_IDLE` waits for a request. The *accept* transition moves it to `ST_ACCESS`, where a phase counter runs. The *finish* transition takes it back to `ST_IDLE` in the last cycle of the access. In every other cycle of an access the state is held and the counter advances.

Top module: `memstrobe_timer`

## Requirements
- R1: While reset is asserted and whenever no access is running, every chip-select line, the read strobe and the write strobe are high. In those cycles the acknowledge is low and the address and byte-select outputs are zero.
- R2: A request seen high in an idle cycle starts an access in the next cycle. Only the chip-select line numbered by the request's chip-select input may go low, and the other lines stay high.
- R3: In normal mode, cycles of an access are numbered from 0. The strobe for the access direction is low in cycle k exactly when setup <= k < setup + pulse, using the programmed strobe setup and strobe pulse.
- R4: In normal mode the selected chip-select line is low in cycle k exactly when cs_setup <= k < cs_setup + cs_pulse, using the programmed chip-select values.
- R5: An access lasts the programmed cycle length, and a cycle length of 0 counts as 1. The acknowledge is high only in the last cycle. Any strobe or chip-select window that would reach past the last cycle is cut off there.
- R6: The configuration input holds 10 fields of CNT_W bits per chip select, with chip select n starting at field 10*n. The field order is:
  - 0 read strobe setup
  - 1 read strobe pulse
  - 2 read cs setup
  - 3 read cs pulse
  - 4 read cycle
  - 5 write strobe setup
  - 6 write strobe pulse
  - 7 write cs setup
  - 8 write cs pulse
  - 9 write cycle

  Field f of chip select n sits at bits [(10*n+f)*CNT_W +: CNT_W].
- R7: A read in slow-clock mode lasts 2 cycles. The chip select is low in both cycles. The read strobe is high in cycle 0 and low in cycle 1.
- R8: A write in slow-clock mode lasts 3 cycles. The chip select is low in all three cycles. The write strobe is low only in cycle 1.
- R9: In slow-clock mode the fixed timings apply to every chip select, and the programmed values have no effect.
- R10: The slow-clock indication is sampled only in the accept cycle. A change during an access does not alter that access.
- R11: The address and byte-select outputs carry the values presented in the accept cycle, for every cycle of the access. Later changes on the host inputs do not affect them.
- R12: The cycle after an acknowledge is always idle. A request present in that cycle is accepted there.
- R13: The strobe of the other direction stays high for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk_i | input | 1 | Slow-clock indication from power management |
| cfg_timing_i | input | NUM_CS*10*CNT_W | Programmed timing fields (layout in R6) |
| req_i | input | 1 | Host access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| cs_sel_i | input | CS_W | Chip select number for the request |
| addr_i | input | ADDR_W | Request address |
| bsel_i | input | BSEL_W | Request byte selects |
| ack_o | output | 1 | High in the last cycle of an access |
| cs_n_o | output | NUM_CS | Active-low chip selects |
| rd_n_o | output | 1 | Active-low read strobe |
| we_n_o | output | 1 | Active-low write strobe |
| addr_o | output | ADDR_W | Memory address |
| bsel_o | output | BSEL_W | Memory byte selects |

## Verification
Some behaviours are checked on every cycle:
- quiet outputs while idle
- at most one chip select low
- the two strobes never low together
- a stable address through an access
- the idle cycle after each acknowledge
- the exact fixed waveforms of slow-clock reads and writes, counted from the accept cycle

Other behaviours can only be shown by the bench's scenarios:
- whether the programmed windows land in the right cycles for each chip select and direction
- the treatment of a zero cycle length
- the cut-off of windows that run past the cycle end
- that a slow-clock change in the middle of an access is ignored

// File: rtl/mst_pkg.sv
package mst_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } mst_state_e;

    // field index inside one direction's timing group
    localparam int unsigned FLD_STRB_SETUP = 0;
    localparam int unsigned FLD_STRB_PULSE = 1;
    localparam int unsigned FLD_CS_SETUP   = 2;
    localparam int unsigned FLD_CS_PULSE   = 3;
    localparam int unsigned FLD_CYCLE      = 4;
    localparam int unsigned FLD_PER_DIR    = 5;
    localparam int unsigned FLD_PER_CS     = 2 * FLD_PER_DIR;

    // built-in timings used while the clock runs slowly
    localparam int unsigned SLOW_RD_STRB_SETUP = 1;
    localparam int unsigned SLOW_RD_STRB_PULSE = 1;
    localparam int unsigned SLOW_RD_CS_SETUP   = 0;
    localparam int unsigned SLOW_RD_CS_PULSE   = 2;
    localparam int unsigned SLOW_RD_CYCLE      = 2;
    localparam int unsigned SLOW_WR_STRB_SETUP = 1;
    localparam int unsigned SLOW_WR_STRB_PULSE = 1;
    localparam int unsigned SLOW_WR_CS_SETUP   = 0;
    localparam int unsigned SLOW_WR_CS_PULSE   = 3;
    localparam int unsigned SLOW_WR_CYCLE      = 3;

endpackage

// File: rtl/mst_timing_sel.sv
module mst_timing_sel
    import mst_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned CNT_W  = 4,
    localparam int unsigned CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int unsigned CFG_W = NUM_CS * FLD_PER_CS * CNT_W
) (
    input  logic [CFG_W-1:0] cfg,
    input  logic [CS_W-1:0]  cs_sel,
    input  logic             wr,
    input  logic             slow,
    output logic [CNT_W-1:0] strb_setup,
    output logic [CNT_W-1:0] strb_pulse,
    output logic [CNT_W-1:0] cs_setup,
    output logic [CNT_W-1:0] cs_pulse,
    output logic [CNT_W-1:0] cycle
);

    int unsigned base;
    logic [CNT_W-1:0] cyc_raw;

    always_comb begin
        base = ((int'(cs_sel) < int'(NUM_CS)) ? int'(cs_sel) : 0) * FLD_PER_CS
             + (wr ? FLD_PER_DIR : 0);
        if (slow) begin
            strb_setup = wr ? CNT_W'(SLOW_WR_STRB_SETUP) : CNT_W'(SLOW_RD_STRB_SETUP);
            strb_pulse = wr ? CNT_W'(SLOW_WR_STRB_PULSE) : CNT_W'(SLOW_RD_STRB_PULSE);
            cs_setup   = wr ? CNT_W'(SLOW_WR_CS_SETUP)   : CNT_W'(SLOW_RD_CS_SETUP);
            cs_pulse   = wr ? CNT_W'(SLOW_WR_CS_PULSE)   : CNT_W'(SLOW_RD_CS_PULSE);
            cyc_raw    = wr ? CNT_W'(SLOW_WR_CYCLE)      : CNT_W'(SLOW_RD_CYCLE);
        end else begin
            strb_setup = cfg[(base + FLD_STRB_SETUP) * CNT_W +: CNT_W];
            strb_pulse = cfg[(base + FLD_STRB_PULSE) * CNT_W +: CNT_W];
            cs_setup   = cfg[(base + FLD_CS_SETUP)   * CNT_W +: CNT_W];
            cs_pulse   = cfg[(base + FLD_CS_PULSE)   * CNT_W +: CNT_W];
            cyc_raw    = cfg[(base + FLD_CYCLE)      * CNT_W +: CNT_W];
        end
        // a zero-length cycle still occupies one clock
        cycle = (cyc_raw == '0) ? CNT_W'(1) : cyc_raw;
    end

endmodule

// File: rtl/mst_window.sv
module mst_window #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] setup,
    input  logic [CNT_W-1:0] pulse,
    output logic             active
);

    logic [CNT_W:0] lo, hi, pos;

    always_comb begin
        lo     = {1'b0, setup};
        hi     = lo + {1'b0, pulse};
        pos    = {1'b0, cnt};
        active = en && (pos >= lo) && (pos < hi);
    end

endmodule

// File: rtl/memstrobe_timer.sv
module memstrobe_timer
    import mst_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned BSEL_W = 4,
    localparam int unsigned CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int unsigned CFG_W = NUM_CS * FLD_PER_CS * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk_i,
    input  logic [CFG_W-1:0]  cfg_timing_i,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [CS_W-1:0]   cs_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BSEL_W-1:0] bsel_i,
    output logic              ack_o,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic              rd_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BSEL_W-1:0] bsel_o
);

    mst_state_e state_q, state_d;

    logic [CNT_W-1:0]  cnt_q;
    logic              wr_q;
    logic [CS_W-1:0]   cs_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BSEL_W-1:0] bsel_q;
    logic [CNT_W-1:0]  strb_setup_q, strb_pulse_q, cs_setup_q, cs_pulse_q, cyc_q;

    logic [CNT_W-1:0]  sel_strb_setup, sel_strb_pulse, sel_cs_setup, sel_cs_pulse, sel_cyc;
    logic              in_access, last_cyc, strb_act, cs_act;

    // timing set chosen at accept time; slow indication sampled only here
    mst_timing_sel #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_sel (
        .cfg        (cfg_timing_i),
        .cs_sel     (cs_sel_i),
        .wr         (wr_i),
        .slow       (slow_clk_i),
        .strb_setup (sel_strb_setup),
        .strb_pulse (sel_strb_pulse),
        .cs_setup   (sel_cs_setup),
        .cs_pulse   (sel_cs_pulse),
        .cycle      (sel_cyc)
    );

    assign in_access = (state_q == ST_ACCESS);
    assign last_cyc  = in_access && (cnt_q == cyc_q - CNT_W'(1));

    // next-state: accept (IDLE->ACCESS), finish (ACCESS->IDLE), otherwise hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i)    state_d = ST_ACCESS;
            ST_ACCESS: if (last_cyc) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            wr_q         <= 1'b0;
            cs_q         <= '0;
            addr_q       <= '0;
            bsel_q       <= '0;
            strb_setup_q <= '0;
            strb_pulse_q <= '0;
            cs_setup_q   <= '0;
            cs_pulse_q   <= '0;
            cyc_q        <= CNT_W'(1);
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (req_i) begin
                        wr_q         <= wr_i;
                        cs_q         <= cs_sel_i;
                        addr_q       <= addr_i;
                        bsel_q       <= bsel_i;
                        strb_setup_q <= sel_strb_setup;
                        strb_pulse_q <= sel_strb_pulse;
                        cs_setup_q   <= sel_cs_setup;
                        cs_pulse_q   <= sel_cs_pulse;
                        cyc_q        <= sel_cyc;
                    end
                end
                ST_ACCESS: cnt_q <= last_cyc ? '0 : cnt_q + CNT_W'(1);
                default:   cnt_q <= '0;
            endcase
        end
    end

    mst_window #(.CNT_W(CNT_W)) u_strb_win (
        .en (in_access), .cnt(cnt_q), .setup(strb_setup_q), .pulse(strb_pulse_q), .active(strb_act)
    );

    mst_window #(.CNT_W(CNT_W)) u_cs_win (
        .en (in_access), .cnt(cnt_q), .setup(cs_setup_q), .pulse(cs_pulse_q), .active(cs_act)
    );

    // output process
    always_comb begin
        ack_o  = last_cyc;
        rd_n_o = !(strb_act && !wr_q);
        we_n_o = !(strb_act &&  wr_q);
        addr_o = in_access ? addr_q : '0;
        bsel_o = in_access ? bsel_q : '0;
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n_o[i] = !(cs_act && (cs_q == CS_W'(i)));
    end

endmodule

// File: rtl/mst_checks.sv
module mst_checks #(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned BSEL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              req_i,
    input logic              wr_i,
    input logic              slow_clk_i,
    input logic              ack_o,
    input logic [NUM_CS-1:0] cs_n_o,
    input logic              rd_n_o,
    input logic              we_n_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [BSEL_W-1:0] bsel_o
);

    logic       chk_slow, chk_wr;
    logic [1:0] chk_k;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_slow <= 1'b0;
            chk_wr   <= 1'b0;
            chk_k    <= 2'd0;
        end else if (!busy && req_i) begin
            chk_slow <= slow_clk_i;
            chk_wr   <= wr_i;
            chk_k    <= 2'd0;
        end else if (busy && chk_k != 2'd3) begin
            chk_k <= chk_k + 2'd1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n_o && we_n_o && (&cs_n_o) && !ack_o && addr_o == '0 && bsel_o == '0));

    assert_single_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n_o) <= 1);

    assert_ack_then_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> (!busy && !ack_o));

    assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n_o || we_n_o);

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack_o) |=> ($stable(addr_o) && $stable(bsel_o)));

    assert_slow_rd_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && chk_slow && !chk_wr && chk_k == 2'd0)
            |-> (rd_n_o && !ack_o && $countones(~cs_n_o) == 1));

    assert_slow_rd_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && chk_slow && !chk_wr && chk_k == 2'd1)
            |-> (!rd_n_o && ack_o && $countones(~cs_n_o) == 1));

    assert_slow_wr_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && chk_slow && chk_wr && chk_k == 2'd0)
            |-> (we_n_o && !ack_o && $countones(~cs_n_o) == 1));

    assert_slow_wr_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && chk_slow && chk_wr && chk_k == 2'd1)
            |-> (!we_n_o && !ack_o && $countones(~cs_n_o) == 1));

    assert_slow_wr_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && chk_slow && chk_wr && chk_k == 2'd2)
            |-> (we_n_o && ack_o && $countones(~cs_n_o) == 1));

endmodule

bind memstrobe_timer mst_checks #(
    .NUM_CS (NUM_CS),
    .ADDR_W (ADDR_W),
    .BSEL_W (BSEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (state_q == mst_pkg::ST_ACCESS),
    .req_i      (req_i),
    .wr_i       (wr_i),
    .slow_clk_i (slow_clk_i),
    .ack_o      (ack_o),
    .cs_n_o     (cs_n_o),
    .rd_n_o     (rd_n_o),
    .we_n_o     (we_n_o),
    .addr_o     (addr_o),
    .bsel_o     (bsel_o)
);

// File: tb/sim_memstrobe_timer.sv
`timescale 1ns/1ps
module sim_memstrobe_timer;

    localparam int NUM_CS = 4;
    localparam int CNT_W  = 4;
    localparam int ADDR_W = 24;
    localparam int BSEL_W = 4;
    localparam int CS_W   = 2;
    localparam int CFG_W  = NUM_CS * 10 * CNT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              slow_clk_i = 1'b0;
    logic [CFG_W-1:0]  cfg = '0;
    logic              req_i = 1'b0;
    logic              wr_i = 1'b0;
    logic [CS_W-1:0]   cs_sel_i = '0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [BSEL_W-1:0] bsel_i = '0;
    logic              ack_o;
    logic [NUM_CS-1:0] cs_n_o;
    logic              rd_n_o, we_n_o;
    logic [ADDR_W-1:0] addr_o;
    logic [BSEL_W-1:0] bsel_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    memstrobe_timer #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BSEL_W(BSEL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_clk_i(slow_clk_i), .cfg_timing_i(cfg),
        .req_i(req_i), .wr_i(wr_i), .cs_sel_i(cs_sel_i), .addr_i(addr_i), .bsel_i(bsel_i),
        .ack_o(ack_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .we_n_o(we_n_o),
        .addr_o(addr_o), .bsel_o(bsel_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // expected timing field (R6 layout, R7/R8 fixed values)
    function automatic int fld(input int cs, input bit wr, input bit slow, input int idx);
        int rd_slow[5] = '{1, 1, 0, 2, 2};
        int wr_slow[5] = '{1, 1, 0, 3, 3};
        if (slow) return wr ? wr_slow[idx] : rd_slow[idx];
        return int'(cfg[(cs * 10 + (wr ? 5 : 0) + idx) * CNT_W +: CNT_W]);
    endfunction

    task automatic set_fld(input int cs, input bit wr, input int idx, input int val);
        cfg[(cs * 10 + (wr ? 5 : 0) + idx) * CNT_W +: CNT_W] = CNT_W'(val);
    endtask

    task automatic check_idle(input string req);
        chk(cs_n_o == '1, req, cs_n_o, 15);
        chk(rd_n_o && we_n_o, req, {rd_n_o, we_n_o}, 3);
        chk(!ack_o, req, ack_o, 0);
        chk(addr_o == '0 && bsel_o == '0, req, addr_o, 0);
    endtask

    // caller is at a negedge with the design idle
    task automatic run_access(input int cs, input bit wr, input logic [ADDR_W-1:0] a,
                              input logic [BSEL_W-1:0] b, input bit slow, input bit flip);
        int ss, sp, cs0, cp, cyc;
        string ts, tc;
        check_idle("R12");
        slow_clk_i = slow; req_i = 1'b1; wr_i = wr; cs_sel_i = CS_W'(cs);
        addr_i = a; bsel_i = b;
        ss  = fld(cs, wr, slow, 0);
        sp  = fld(cs, wr, slow, 1);
        cs0 = fld(cs, wr, slow, 2);
        cp  = fld(cs, wr, slow, 3);
        cyc = fld(cs, wr, slow, 4);
        if (cyc == 0) cyc = 1;
        ts = slow ? (flip ? "R10" : (wr ? "R8" : "R7")) : (flip ? "R10" : "R3,R6");
        tc = slow ? "R9" : "R4,R2";
        for (int k = 0; k < cyc; k++) begin
            bit e_strb, e_cs;
            logic [NUM_CS-1:0] e_csn;
            @(negedge clk);
            e_strb = (k >= ss) && (k < ss + sp);
            e_cs   = (k >= cs0) && (k < cs0 + cp);
            e_csn  = e_cs ? ~(NUM_CS'(1) << cs) : '1;
            if (wr) begin
                chk(we_n_o == !e_strb, ts, we_n_o, !e_strb);
                chk(rd_n_o, "R13", rd_n_o, 1);
            end else begin
                chk(rd_n_o == !e_strb, ts, rd_n_o, !e_strb);
                chk(we_n_o, "R13", we_n_o, 1);
            end
            chk(cs_n_o == e_csn, tc, cs_n_o, e_csn);
            chk(ack_o == (k == cyc - 1), "R5", ack_o, k == cyc - 1);
            chk(addr_o == a && bsel_o == b, "R11", addr_o, a);
            if (k == 0) begin
                req_i  = 1'b0;
                addr_i = ~a;
                bsel_i = ~b;
                if (flip) slow_clk_i = ~slow;
            end
        end
        req_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd7719));
        for (int n = 0; n < CFG_W / 32; n++) cfg[n * 32 +: 32] = $urandom;
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");
        repeat (3) @(negedge clk);
        check_idle("R2");

        // directed: window running past the cycle end is cut (R5)
        set_fld(2, 0, 0, 3); set_fld(2, 0, 1, 10); set_fld(2, 0, 2, 0);
        set_fld(2, 0, 3, 15); set_fld(2, 0, 4, 5);
        run_access(2, 0, 24'h00ABCD, 4'h5, 0, 0);
        // zero cycle length behaves as one cycle (R5)
        set_fld(1, 1, 0, 0); set_fld(1, 1, 1, 2); set_fld(1, 1, 2, 0);
        set_fld(1, 1, 3, 1); set_fld(1, 1, 4, 0);
        run_access(1, 1, 24'h123456, 4'hA, 0, 0);
        // zero pulse: strobe never asserts
        set_fld(3, 1, 1, 0); set_fld(3, 1, 4, 6);
        run_access(3, 1, 24'h000001, 4'hF, 0, 0);
        // slow mode on each chip select with contradicting settings (R9)
        for (int c = 0; c < NUM_CS; c++) begin
            run_access(c, 0, 24'(32'h1000 * c + 7), 4'(c), 1, 0);
            run_access(c, 1, 24'(32'h2000 * c + 9), 4'(c + 1), 1, 0);
        end
        // mid-access indication change (R10)
        run_access(0, 1, 24'h0F0F0F, 4'h3, 1, 1);
        run_access(2, 0, 24'h0F0F0F, 4'h3, 0, 1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0)
                for (int n = 0; n < CFG_W / 32; n++) cfg[n * 32 +: 32] = $urandom;
            run_access(int'($urandom % NUM_CS), 1'($urandom), 24'($urandom), 4'($urandom),
                       ($urandom % 4) == 0, ($urandom % 8) == 0);
        end
        check_idle("R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule